// File: doc/BRIEF.md
# Speculative Store Queue with Retirement Tracking

This block is a circular queue of stores placed between the store execution stage of an out-of-order core and the write port of its data cache. A store enters at the tail as soon as it executes and stays in program order. While it waits it is speculative. A retire pulse promotes the oldest speculative entry to graduated. Only graduated entries drain from the head to the cache, so a store on a wrong path can never reach memory or another core.

A misprediction flush drops every speculative entry in one cycle. Graduated entries survive and keep draining. The cache side is a valid/ready commit port. A beat transfers on a cycle where `cm_valid` and `cm_ready` are both high. While `cm_ready` is low the offered head store is held unchanged, and newly executed stores are still accepted. On the store input side, `st_ready` is low when all entries are occupied or a flush is active, and a store offered while it is low is not taken.

Two hardware threads share the queue. Each thread has a forwarding lookup port. A thread sees all of its own matching stores. It sees only graduated stores of its sibling. The youngest eligible store whose full word address matches supplies the data. The depth must be a power of two.

Top module: `spec_store_buf`

## Requirements
- R1: A store is accepted when `st_valid` and `st_ready` are high and is appended behind all older stores. `st_ready` is high exactly when fewer than DEPTH entries are held and `flush` is low. A store offered while `st_ready` is low is not taken.
- R2: `cm_valid` is high exactly when the oldest held entry is graduated, and `cm_addr`/`cm_data` show that entry. A transfer on `cm_valid && cm_ready` removes it, so the cache receives stores strictly in acceptance order.
- R3: While `cm_valid` is high and `cm_ready` is low, the head store stays offered with stable address and data. Stores keep being accepted during the stall.
- R4: A `retire` pulse graduates the oldest speculative entry, one per cycle. A `retire` while no speculative entry is held has no effect.
- R5: A `flush` removes every speculative entry at the clock edge and keeps every graduated one. A `retire` in the same cycle is applied before the flush, so the entry it graduates survives.
- R6: A commit transfer in a flush cycle still takes place.
- R7: Lookup port p (thread p, with `st_tid` = p) reports a hit on a word address equal to any held entry of thread p, whether speculative or graduated. It also reports a hit on graduated entries of the other thread. When several entries are eligible, the youngest one supplies `fw_data[p]`.
- R8: A speculative entry of the other thread is never eligible for lookup port p. With no eligible match, `fw_hit[p]` is 0.
- R9: After reset the queue is empty: `st_ready` = 1, `cm_valid` = 0, and no lookup hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Executed store offered |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_tid | input | TW | Thread of the offered store |
| st_addr | input | AW | Word address of the store |
| st_data | input | DW | Store data |
| retire | input | 1 | Oldest speculative store has retired |
| flush | input | 1 | Misprediction: drop speculative stores |
| cm_valid | output | 1 | Graduated head store offered to cache |
| cm_ready | input | 1 | Cache accepts the offered store |
| cm_addr | output | AW | Address of offered store |
| cm_data | output | DW | Data of offered store |
| lk_addr | input | NTHR x AW | Lookup address, one per thread |
| fw_hit | output | NTHR | Forwarding hit, one per thread |
| fw_data | output | NTHR x DW | Forwarded data, one per thread |

## Verification
The bound checks watch every cycle for several properties: the occupancy bound, refusal while full, and the stability of a stalled commit beat. They also check that an idle retire leaves the graduation point in place, that no speculative entry remains after a flush, and that the head advances when a commit coincides with a flush. Two properties can only be shown by comparing against a reference queue across the bench scenarios: that the cache receives the right stores in the right order, and that forwarding picks the youngest eligible entry while hiding the sibling's speculative stores. Those scenarios are a fill to full, stalled drains that still take stores, flushes with and without graduated entries, and random mixes.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int AW   = 32;
  localparam int DW   = 32;
  localparam int NTHR = 2;
  localparam int TW   = (NTHR > 1) ? $clog2(NTHR) : 1;

  typedef struct packed {
    logic [TW-1:0] tid;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } entry_t;
endpackage

// File: rtl/ssb_ptr_ctl.sv
module ssb_ptr_ctl #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alloc_req,
  input  logic        retire,
  input  logic        flush,
  input  logic        cm_ready,
  output logic [PW:0] head,
  output logic [PW:0] gptr,
  output logic [PW:0] tail,
  output logic [PW:0] occ,
  output logic [PW:0] gcnt,
  output logic        st_ready,
  output logic        alloc_fire,
  output logic        cm_valid
);
  logic        full, spec_any, ret_ok, commit_fire;
  logic [PW:0] gptr_n;

  always_comb begin
    occ         = tail - head;
    gcnt        = gptr - head;
    full        = (occ == (PW+1)'(DEPTH));
    spec_any    = (gptr != tail);
    st_ready    = !full && !flush;
    alloc_fire  = alloc_req && st_ready;
    cm_valid    = (gcnt != '0);
    commit_fire = cm_valid && cm_ready;
    ret_ok      = retire && spec_any;
    gptr_n      = gptr + (PW+1)'(ret_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      gptr <= '0;
      tail <= '0;
    end else begin
      head <= head + (PW+1)'(commit_fire);
      gptr <= gptr_n;
      if (flush) tail <= gptr_n;
      else       tail <= tail + (PW+1)'(alloc_fire);
    end
  end
endmodule

// File: rtl/ssb_storage.sv
module ssb_storage #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           wr_en,
  input  logic [PW-1:0]                  wr_idx,
  input  ssb_pkg::entry_t                wr_ent,
  input  logic [PW-1:0]                  rd_idx,
  output ssb_pkg::entry_t                rd_ent,
  output ssb_pkg::entry_t [DEPTH-1:0]    ents
);
  ssb_pkg::entry_t [DEPTH-1:0] mem;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_ent;
  end

  assign rd_ent = mem[rd_idx];
  assign ents   = mem;
endmodule

// File: rtl/ssb_fwd.sv
module ssb_fwd #(
  parameter int DEPTH = 8,
  parameter int PID   = 0,
  localparam int PW = $clog2(DEPTH)
) (
  input  ssb_pkg::entry_t [DEPTH-1:0] ents,
  input  logic [PW:0]                 head,
  input  logic [PW:0]                 occ,
  input  logic [PW:0]                 gcnt,
  input  logic [ssb_pkg::AW-1:0]      lk_addr,
  output logic                        hit,
  output logic [ssb_pkg::DW-1:0]      data
);
  always_comb begin
    hit  = 1'b0;
    data = '0;
    // oldest to youngest; a later match overrides an earlier one
    for (int o = 0; o < DEPTH; o++) begin
      logic [PW-1:0]   idx;
      logic [PW:0]     ov;
      ssb_pkg::entry_t e;
      ov  = (PW+1)'(o);
      idx = head[PW-1:0] + PW'(o);
      e   = ents[idx];
      if ((ov < occ) && (e.addr == lk_addr) &&
          ((e.tid == ssb_pkg::TW'(PID)) || (ov < gcnt))) begin
        hit  = 1'b1;
        data = e.data;
      end
    end
  end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf #(
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int AW   = ssb_pkg::AW,
  localparam int DW   = ssb_pkg::DW,
  localparam int TW   = ssb_pkg::TW,
  localparam int NTHR = ssb_pkg::NTHR
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_valid,
  output logic                     st_ready,
  input  logic [TW-1:0]            st_tid,
  input  logic [AW-1:0]            st_addr,
  input  logic [DW-1:0]            st_data,
  input  logic                     retire,
  input  logic                     flush,
  output logic                     cm_valid,
  input  logic                     cm_ready,
  output logic [AW-1:0]            cm_addr,
  output logic [DW-1:0]            cm_data,
  input  logic [NTHR-1:0][AW-1:0]  lk_addr,
  output logic [NTHR-1:0]          fw_hit,
  output logic [NTHR-1:0][DW-1:0]  fw_data
);
  logic [PW:0] head, gptr, tail, occ, gcnt;
  logic        alloc_fire;
  ssb_pkg::entry_t                wr_ent, rd_ent;
  ssb_pkg::entry_t [DEPTH-1:0]    ents;

  ssb_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc_req(st_valid), .retire(retire),
    .flush(flush), .cm_ready(cm_ready), .head(head), .gptr(gptr),
    .tail(tail), .occ(occ), .gcnt(gcnt), .st_ready(st_ready),
    .alloc_fire(alloc_fire), .cm_valid(cm_valid)
  );

  assign wr_ent = '{tid: st_tid, addr: st_addr, data: st_data};

  ssb_storage #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .wr_en(alloc_fire), .wr_idx(tail[PW-1:0]), .wr_ent(wr_ent),
    .rd_idx(head[PW-1:0]), .rd_ent(rd_ent), .ents(ents)
  );

  assign cm_addr = rd_ent.addr;
  assign cm_data = rd_ent.data;

  for (genvar p = 0; p < NTHR; p++) begin : g_fwd
    ssb_fwd #(.DEPTH(DEPTH), .PID(p)) u_fwd (
      .ents(ents), .head(head), .occ(occ), .gcnt(gcnt),
      .lk_addr(lk_addr[p]), .hit(fw_hit[p]), .data(fw_data[p])
    );
  end
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   st_ready,
  input logic                   retire,
  input logic                   flush,
  input logic                   cm_valid,
  input logic                   cm_ready,
  input logic [ssb_pkg::AW-1:0] cm_addr,
  input logic [ssb_pkg::DW-1:0] cm_data,
  input logic [PW:0]            head,
  input logic [PW:0]            gptr,
  input logic [PW:0]            tail
);
  logic [PW:0] c_occ;
  assign c_occ = tail - head;

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    c_occ <= (PW+1)'(DEPTH));

  p_full_refuse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (c_occ == (PW+1)'(DEPTH)) |-> !st_ready);

  p_commit_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_ready) |=> (head == $past(head) + 1'b1));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=> (cm_valid && $stable(cm_addr) && $stable(cm_data)));

  p_idle_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && (gptr == tail) && !flush) |=> (gptr == $past(gptr)));

  p_flush_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tail == gptr));

  p_flush_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && cm_valid && cm_ready) |=> (head == $past(head) + 1'b1));
endmodule

bind spec_store_buf ssb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .retire(retire),
  .flush(flush), .cm_valid(cm_valid), .cm_ready(cm_ready),
  .cm_addr(cm_addr), .cm_data(cm_data), .head(head), .gptr(gptr), .tail(tail)
);

// File: tb/spec_store_buf_test.sv
`timescale 1ns/1ps
module spec_store_buf_test;
  localparam int DEPTH = 8;
  localparam int AW = ssb_pkg::AW;
  localparam int DW = ssb_pkg::DW;
  localparam int TW = ssb_pkg::TW;
  localparam int NT = ssb_pkg::NTHR;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, st_ready, retire = 1'b0, flush = 1'b0;
  logic [TW-1:0] st_tid = '0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic cm_valid, cm_ready = 1'b0;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_data;
  logic [NT-1:0][AW-1:0] lk_addr = '0;
  logic [NT-1:0] fw_hit;
  logic [NT-1:0][DW-1:0] fw_data;

  always #5 clk = ~clk;

  spec_store_buf #(.DEPTH(DEPTH)) uut (.*);

  typedef struct {
    logic [TW-1:0] tid;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    bit g;
  } ment_t;
  ment_t q[$];

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R2";

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", t, act, exp, $time);
    end
  endtask

  function automatic bit exp_hit(int p, logic [AW-1:0] a, output logic [DW-1:0] d);
    bit h = 0;
    d = '0;
    foreach (q[i])
      if (q[i].addr == a && (int'(q[i].tid) == p || q[i].g)) begin
        h = 1; d = q[i].data;
      end
    return h;
  endfunction

  task automatic step(bit sv, logic [TW-1:0] tid, logic [AW-1:0] a,
                      logic [DW-1:0] d, bit ret, bit fl, bit rdy);
    bit er, ecv, eh;
    logic [DW-1:0] ed;
    @(negedge clk);
    st_valid = sv; st_tid = tid; st_addr = a; st_data = d;
    retire = ret; flush = fl; cm_ready = rdy;
    for (int p = 0; p < NT; p++) lk_addr[p] = AW'(($urandom % 8) * 4);
    #1;
    er  = (q.size() < DEPTH) && !fl;
    ecv = (q.size() > 0) && q[0].g;
    chk("R1 st_ready", 64'(st_ready), 64'(er));
    chk({tag, " cm_valid"}, 64'(cm_valid), 64'(ecv));
    if (ecv) begin
      chk({tag, " cm_addr"}, 64'(cm_addr), 64'(q[0].addr));
      chk({tag, " cm_data"}, 64'(cm_data), 64'(q[0].data));
    end
    for (int p = 0; p < NT; p++) begin
      eh = exp_hit(p, lk_addr[p], ed);
      chk("R7 R8 fw_hit", 64'(fw_hit[p]), 64'(eh));
      if (eh) chk("R7 fw_data", 64'(fw_data[p]), 64'(ed));
    end
    // model update for the coming edge
    if (ecv && rdy) void'(q.pop_front());
    if (ret)
      foreach (q[i]) if (!q[i].g) begin q[i].g = 1; break; end
    if (fl)
      while (q.size() > 0 && !q[q.size()-1].g) void'(q.pop_back());
    if (sv && er) q.push_back('{tid, a, d, 1'b0});
  endtask

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) step(0, '0, '0, '0, 0, 0, rdy);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R9 st_ready", 64'(st_ready), 64'd1);
    chk("R9 cm_valid", 64'(cm_valid), 64'd0);
    chk("R9 fw_hit", 64'(fw_hit), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1: fill past capacity; the ninth store is refused
    tag = "R1";
    for (int i = 0; i < DEPTH + 1; i++)
      step(1, TW'(i % 2), AW'(i * 4), DW'(32'hA000 + i), 0, 0, 0);
    idle(1, 0);
    // R4: graduate three, no commits yet
    tag = "R4";
    for (int i = 0; i < 3; i++) step(0, '0, '0, '0, 1, 0, 0);
    // R5: flush keeps three graduated, retire in same cycle survives
    tag = "R5";
    step(0, '0, '0, '0, 1, 1, 0);
    idle(1, 0);
    // R3: stalled head, new stores still accepted
    tag = "R3";
    for (int i = 0; i < 4; i++)
      step(1, 1'b1, AW'(4), DW'(32'hB000 + i), 0, 0, 0);
    idle(2, 0);
    // R6: commit together with a flush
    tag = "R6";
    step(0, '0, '0, '0, 0, 1, 1);
    idle(1, 0);
    // R4: retire with nothing speculative is ignored
    tag = "R4";
    idle(4, 1);
    step(0, '0, '0, '0, 1, 0, 1);
    step(1, '0, AW'(8), DW'(32'hC0DE), 0, 0, 1);
    idle(3, 1);
    // R5: flush with nothing graduated empties the queue
    tag = "R5";
    step(1, '0, AW'(12), DW'(32'hD00D), 0, 0, 1);
    step(0, '0, '0, '0, 0, 1, 1);
    idle(2, 1);

    tag = "R2";
    for (int i = 0; i < 4000; i++)
      step(($urandom % 10) < 6, TW'($urandom % NT), AW'(($urandom % 8) * 4),
           DW'($urandom), ($urandom % 10) < 4, ($urandom % 20) == 0,
           ($urandom % 10) < 6);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule